// File: doc/BRIEF.md
# Data-Strobe Line Codec

This block sits between a parallel link-side data path and a serial data-strobe line pair. For transmission it takes a group of 2 or 4 bits once per system clock, sends them one after another with the lowest lane first, and drives a data line and a strobe line. The strobe changes only in serial slots where the data bit repeats, so exactly one of the two lines changes per bit. For reception it watches a data line and a strobe line, recognises each new bit from a change in their exclusive-OR, and collects the bits into groups of 2 or 4. Each group is presented on the link side for exactly one system clock period.

The serial side is modelled on a single fast clock running at four system slots per system period. The block brings out a system-clock marker that shows where the period ends. A mode input selects 4 lanes, which gives one bit per fast cycle, or 2 lanes, which gives one bit per two fast cycles. The line roles swap between the two directions. Outgoing data goes on the B line and outgoing strobe on the A line. Incoming data arrives on the A line and incoming strobe on the B line. Every recovered bit is also re-encoded onto a repeat line pair, so that other connected ports can forward the traffic.

Top module: `ds_codec`

## Requirements
- R1: While rst_n is low, tx_line_a, tx_line_b, rpt_line_a, rpt_line_b, rx_valid and sys_tick are all 0.
- R2: sys_tick is high for one fast cycle in every four. After rst_n rises it is first high in the fourth fast cycle. Each such cycle closes one system period.
- R3: wide_mode is captured at the edge that ends a sys_tick cycle and holds for the following period. With wide_mode=1 the 4 lanes tx_word[3:0] each occupy one fast cycle. With wide_mode=0 only lanes tx_word[1:0] are sent, each for two fast cycles, and lanes 2 and 3 have no effect.
- R4: tx_word and tx_en are captured at the edge that ends a sys_tick cycle. The bit of lane 0 is on the line in the next fast cycle, followed by lane 1 and then the higher lanes in turn.
- R5: The transmit data bit appears on tx_line_b and the strobe on tx_line_a. At each bit the strobe inverts if the bit equals the previous data bit and holds otherwise. A period with tx_en=0 drives both lines to 0, and encoding restarts from data 0 and strobe 0.
- R6: rx_line_a carries received data and rx_line_b carries received strobe, and both are sampled every fast cycle. A bit is recognised whenever rx_line_a XOR rx_line_b differs from its value in the previous sample, and that bit is the rx_line_a value.
- R7: The first recovered bit after rx_en rises goes to lane 0. When 2 bits (wide_mode=0) or 4 bits (wide_mode=1) have been collected, the group appears on rx_word with rx_valid=1 for exactly the next system period. rx_valid and rx_word change only at period boundaries, and unused lanes read 0.
- R8: While rx_en is low, no bit is recognised and the repeat lines return to 0 two cycles later. A partially collected group is discarded.
- R9: Each recovered bit is re-encoded with the rule of R5 onto rpt_line_b (data) and rpt_line_a (strobe). It appears two fast cycles after it was applied to the receive lines.
- R10: With the transmit lines looped back to the receive lines, every transmitted group comes back on rx_word in order and unchanged, apart from the lanes masked off by R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = 4 lanes, 0 = 2 lanes |
| sys_tick | output | 1 | Marks the last fast cycle of each system period |
| tx_en | input | 1 | Transmit the group offered this period |
| tx_word | input | 4 | Parallel transmit group, lane 0 sent first |
| tx_line_a | output | 1 | Transmit strobe line |
| tx_line_b | output | 1 | Transmit data line |
| rx_en | input | 1 | Receiver enable |
| rx_line_a | input | 1 | Receive data line |
| rx_line_b | input | 1 | Receive strobe line |
| rx_word | output | 4 | Recovered parallel group |
| rx_valid | output | 1 | rx_word holds a new group this period |
| rpt_line_a | output | 1 | Repeat strobe line |
| rpt_line_b | output | 1 | Repeat data line |

## Verification
The hardest cases to reach are received bits whose edges do not line up with the system period. Groups can then complete anywhere inside a period and sometimes exactly on the boundary cycle. Some also complete just after a partial group was thrown away when the receiver was disabled. The bench drives the receive lines directly, bit by bit, with held durations that vary between one and three fast cycles, so completions fall on every phase. It toggles rx_en in the middle of a group while the lines keep moving. A loopback sweep over every group value in both lane modes then closes the path end to end.

// File: rtl/ds_pkg.sv
`timescale 1ns/1ps
package ds_pkg;
  // number of lanes in wide mode; narrow mode uses half of them
  localparam int unsigned LANES_MAX = 4;

  // strobe value for the next bit: invert when the data bit repeats
  function automatic logic strobe_next(logic d_prev, logic s_prev, logic d_new);
    return (d_new == d_prev) ? ~s_prev : s_prev;
  endfunction

  // last lane index of one group for the selected mode
  function automatic int unsigned last_lane(logic wide, int unsigned lanes);
    return wide ? lanes - 1 : lanes / 2 - 1;
  endfunction
endpackage

// File: rtl/ds_sys_timer.sv
`timescale 1ns/1ps
module ds_sys_timer #(
  parameter int unsigned LANES = ds_pkg::LANES_MAX
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wide_in,
  output logic                     tick,
  output logic                     wide_cur,
  output logic                     slot_start,
  output logic [$clog2(LANES)-1:0] slot_idx
);
  localparam int unsigned PW = $clog2(LANES);

  logic [PW-1:0] phase;
  logic [PW-1:0] phase_nx;
  logic          wide_nx;

  assign phase_nx = phase + PW'(1);
  assign tick     = (phase == PW'(LANES - 1));
  // mode of the cycle that follows the coming edge
  assign wide_nx  = tick ? wide_in : wide_cur;
  // in narrow mode each bit covers two fast cycles
  assign slot_start = wide_nx | ~phase_nx[0];
  assign slot_idx   = wide_nx ? phase_nx : (phase_nx >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      wide_cur <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (tick) wide_cur <= wide_in;
    end
  end
endmodule

// File: rtl/ds_line_enc.sv
`timescale 1ns/1ps
module ds_line_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_in,
  output logic d_out,
  output logic s_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out <= 1'b0;
      s_out <= 1'b0;
    end else if (clr) begin
      d_out <= 1'b0;
      s_out <= 1'b0;
    end else if (step) begin
      d_out <= bit_in;
      s_out <= ds_pkg::strobe_next(d_out, s_out, bit_in);
    end
  end
endmodule

// File: rtl/ds_tx_ser.sv
`timescale 1ns/1ps
module ds_tx_ser #(
  parameter int unsigned LANES = ds_pkg::LANES_MAX
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     slot_start,
  input  logic [$clog2(LANES)-1:0] slot_idx,
  input  logic                     tx_en,
  input  logic [LANES-1:0]         tx_word,
  output logic                     bit_en,
  output logic                     line_a,
  output logic                     line_b
);
  logic [LANES-1:0] hold_w;
  logic             hold_en;
  logic [LANES-1:0] cur_w;
  logic             nbit;

  // the group captured at this edge starts on the line straight away
  assign cur_w  = tick ? tx_word : hold_w;
  assign bit_en = tick ? tx_en : hold_en;
  assign nbit   = cur_w[slot_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_w  <= '0;
      hold_en <= 1'b0;
    end else if (tick) begin
      hold_w  <= tx_word;
      hold_en <= tx_en;
    end
  end

  // data on B, strobe on A
  ds_line_enc u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (slot_start & ~bit_en),
    .step   (slot_start & bit_en),
    .bit_in (nbit),
    .d_out  (line_b),
    .s_out  (line_a)
  );
endmodule

// File: rtl/ds_rx_deser.sv
`timescale 1ns/1ps
module ds_rx_deser #(
  parameter int unsigned LANES = ds_pkg::LANES_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wide_cur,
  input  logic             rx_en,
  input  logic             line_a,
  input  logic             line_b,
  output logic             en_q,
  output logic             bit_ev,
  output logic             rcv_bit,
  output logic             grp_done,
  output logic [LANES-1:0] word,
  output logic             valid
);
  localparam int unsigned PW = $clog2(LANES);

  logic             a_q, b_q, ref_x, x_now;
  logic [PW-1:0]    cnt;
  logic [PW-1:0]    cnt_last;
  logic [LANES-1:0] acc, acc_nx;
  logic             pend;
  logic [LANES-1:0] pend_w;

  assign x_now    = a_q ^ b_q;
  assign rcv_bit  = a_q;
  assign bit_ev   = en_q & (x_now != ref_x);
  assign cnt_last = PW'(ds_pkg::last_lane(wide_cur, LANES));
  assign grp_done = bit_ev & (cnt == cnt_last);

  always_comb begin
    acc_nx      = (cnt == '0) ? '0 : acc;
    acc_nx[cnt] = a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      en_q  <= 1'b0;
      ref_x <= 1'b0;
      cnt   <= '0;
      acc   <= '0;
    end else begin
      a_q   <= line_a;
      b_q   <= line_b;
      en_q  <= rx_en;
      ref_x <= x_now;
      if (!en_q) begin
        cnt <= '0;
      end else if (bit_ev) begin
        acc <= acc_nx;
        cnt <= grp_done ? '0 : cnt + PW'(1);
      end
    end
  end

  // hand groups over only at system period boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pend_w <= '0;
      word   <= '0;
      valid  <= 1'b0;
    end else if (tick) begin
      pend <= 1'b0;
      if (grp_done) begin
        word  <= acc_nx;
        valid <= 1'b1;
      end else if (pend) begin
        word  <= pend_w;
        valid <= 1'b1;
      end else begin
        valid <= 1'b0;
      end
    end else if (grp_done) begin
      pend   <= 1'b1;
      pend_w <= acc_nx;
    end
  end
endmodule

// File: rtl/ds_codec.sv
`timescale 1ns/1ps
module ds_codec #(
  parameter int unsigned LANES = ds_pkg::LANES_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  output logic             sys_tick,
  input  logic             tx_en,
  input  logic [LANES-1:0] tx_word,
  output logic             tx_line_a,
  output logic             tx_line_b,
  input  logic             rx_en,
  input  logic             rx_line_a,
  input  logic             rx_line_b,
  output logic [LANES-1:0] rx_word,
  output logic             rx_valid,
  output logic             rpt_line_a,
  output logic             rpt_line_b
);
  localparam int unsigned PW = $clog2(LANES);

  // named internal events, observed by the checker
  logic          wide_cur;
  logic          slot_start;
  logic [PW-1:0] slot_idx;
  logic          tx_bit_en;
  logic          rx_en_q;
  logic          bit_ev;
  logic          rcv_bit;
  logic          grp_done;

  ds_sys_timer #(.LANES(LANES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide_in    (wide_mode),
    .tick       (sys_tick),
    .wide_cur   (wide_cur),
    .slot_start (slot_start),
    .slot_idx   (slot_idx)
  );

  ds_tx_ser #(.LANES(LANES)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (sys_tick),
    .slot_start (slot_start),
    .slot_idx   (slot_idx),
    .tx_en      (tx_en),
    .tx_word    (tx_word),
    .bit_en     (tx_bit_en),
    .line_a     (tx_line_a),
    .line_b     (tx_line_b)
  );

  ds_rx_deser #(.LANES(LANES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sys_tick),
    .wide_cur (wide_cur),
    .rx_en    (rx_en),
    .line_a   (rx_line_a),
    .line_b   (rx_line_b),
    .en_q     (rx_en_q),
    .bit_ev   (bit_ev),
    .rcv_bit  (rcv_bit),
    .grp_done (grp_done),
    .word     (rx_word),
    .valid    (rx_valid)
  );

  // recovered stream re-encoded for the other ports
  ds_line_enc u_rpt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~rx_en_q),
    .step   (bit_ev),
    .bit_in (rcv_bit),
    .d_out  (rpt_line_b),
    .s_out  (rpt_line_a)
  );
endmodule

// File: rtl/ds_codec_chk.sv
`timescale 1ns/1ps
module ds_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_tick,
  input logic slot_start,
  input logic tx_bit_en,
  input logic tx_line_a,
  input logic tx_line_b,
  input logic rx_en,
  input logic rx_valid,
  input logic [3:0] rx_word,
  input logic bit_ev,
  input logic grp_done,
  input logic rpt_line_a,
  input logic rpt_line_b
);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> !sys_tick);

  // R5
  tx_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && tx_bit_en) |=> ((tx_line_a ^ tx_line_b) != $past(tx_line_a ^ tx_line_b)));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> $stable({tx_line_a, tx_line_b}));

  // R7
  rx_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_tick |=> ($stable(rx_valid) && $stable(rx_word)));

  // R7
  rx_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && grp_done) |=> rx_valid);

  // R9
  rpt_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ev |=> ((rpt_line_a ^ rpt_line_b) != $past(rpt_line_a ^ rpt_line_b)));

  // R8
  rpt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> ##2 (!rpt_line_a && !rpt_line_b));
endmodule

bind ds_codec ds_codec_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_tick   (sys_tick),
  .slot_start (slot_start),
  .tx_bit_en  (tx_bit_en),
  .tx_line_a  (tx_line_a),
  .tx_line_b  (tx_line_b),
  .rx_en      (rx_en),
  .rx_valid   (rx_valid),
  .rx_word    (rx_word),
  .bit_ev     (bit_ev),
  .grp_done   (grp_done),
  .rpt_line_a (rpt_line_a),
  .rpt_line_b (rpt_line_b)
);

// File: tb/ds_codec_bench.sv
`timescale 1ns/1ps
module ds_codec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0;
  logic tx_en = 1'b0;
  logic [3:0] tx_word = '0;
  logic rx_en = 1'b1;
  logic lb = 1'b1;
  logic drv_a = 1'b0, drv_b = 1'b0;
  logic sys_tick, tx_line_a, tx_line_b, rx_valid, rpt_line_a, rpt_line_b;
  logic [3:0] rx_word;
  logic rx_line_a, rx_line_b;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // loopback: transmit data (B) feeds receive data (A)
  assign rx_line_a = lb ? tx_line_b : drv_a;
  assign rx_line_b = lb ? tx_line_a : drv_b;

  ds_codec u_ds_codec (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .sys_tick(sys_tick),
    .tx_en(tx_en), .tx_word(tx_word), .tx_line_a(tx_line_a), .tx_line_b(tx_line_b),
    .rx_en(rx_en), .rx_line_a(rx_line_a), .rx_line_b(rx_line_b),
    .rx_word(rx_word), .rx_valid(rx_valid),
    .rpt_line_a(rpt_line_a), .rpt_line_b(rpt_line_b)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // own statement of the strobe rule: exactly one line moves per bit
  function automatic logic s_rule(logic dp, logic sp, logic dn);
    return sp ^ ~(dn ^ dp);
  endfunction

  // ---------------- receive monitor ----------------
  logic [3:0] got_q[$];
  logic [3:0] exp_q[$];
  logic prev_tick = 1'b0;
  logic armed = 1'b0;
  logic per_v;
  logic [3:0] per_w;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_tick) begin
        per_v = rx_valid;
        per_w = rx_word;
        armed = 1'b1;
        if (rx_valid) got_q.push_back(rx_word);
      end else if (armed) begin
        // R7 outputs hold for the whole period
        check("R7 hold", {3'b0, rx_valid, rx_word}, {3'b0, per_v, per_w});
      end
      prev_tick = sys_tick;
    end
  end

  task automatic cmp_words(string req);
    check(req, 8'(got_q.size()), 8'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(req, {4'b0, got_q[i]}, {4'b0, exp_q[i]});
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (sys_tick !== 1'b1);
  endtask

  // ---------------- transmit sweep with loopback ----------------
  task automatic run_tx(logic wide);
    logic dm, sm, b;
    lb = 1'b1;
    rx_en = 1'b1;
    dm = 1'b0; sm = 1'b0;
    wait_tick();
    for (int w = 0; w <= 16; w++) begin
      logic [3:0] wv;
      wv = 4'(w);
      wide_mode = wide;
      tx_en = (w < 16);
      tx_word = wv;
      if (w < 16) exp_q.push_back(wide ? wv : (wv & 4'h3));
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (wide || (c % 2 == 0)) begin
          if (w < 16) begin
            b = wv[wide ? c : c / 2];
            sm = s_rule(dm, sm, b);
            dm = b;
          end else begin
            dm = 1'b0; sm = 1'b0;
          end
        end
        // R3 R4 R5: lane order, slot length, B data / A strobe, idle zero
        check("R3 R4 R5 tx line", {6'b0, tx_line_b, tx_line_a}, {6'b0, dm, sm});
      end
    end
    repeat (16) @(negedge clk);
    rx_en = 1'b0;
    repeat (8) @(negedge clk);
    cmp_words(wide ? "R10 loopback wide" : "R10 R3 loopback narrow");
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // ---------------- direct receive ----------------
  logic ml_d = 1'b0, ml_s = 1'b0;
  logic rd = 1'b0, rs = 1'b0;
  logic [1:0] h1 = 2'b0, h2 = 2'b0;

  task automatic cyc_check();
    @(negedge clk);
    // R9 repeat pair two cycles behind the receive lines
    check("R9 repeat", {6'b0, rpt_line_b, rpt_line_a}, {6'b0, h2});
    h2 = h1;
  endtask

  task automatic send_bit(logic b, int hold);
    ml_s = s_rule(ml_d, ml_s, b);
    ml_d = b;
    drv_a = ml_d;
    drv_b = ml_s;
    if (rx_en) begin
      rs = s_rule(rd, rs, b);
      rd = b;
    end
    h1 = {rd, rs};
    for (int i = 0; i < hold; i++) begin
      cyc_check();
      h1 = {rd, rs};
    end
  endtask

  task automatic set_en(logic v);
    rx_en = v;
    if (!v) begin rd = 1'b0; rs = 1'b0; end
    h1 = {rd, rs};
    cyc_check();
    h1 = {rd, rs};
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) begin
      cyc_check();
      h1 = {rd, rs};
    end
  endtask

  task automatic run_rx(logic wide);
    int lanes;
    lanes = wide ? 4 : 2;
    wide_mode = wide;
    wait_tick();
    idle_cycles(8);
    for (int g = 0; g < (1 << lanes); g++) begin
      logic [3:0] gv;
      gv = 4'(g);
      exp_q.push_back(gv);
      for (int k = 0; k < lanes; k++)
        // R6 data on A, strobe on B, holds of varying length
        send_bit(gv[k], wide ? 1 + ((g + k) % 2) : 2 + ((g + k) % 2));
    end
    idle_cycles(16);
    cmp_words(wide ? "R6 R7 rx wide" : "R6 R7 rx narrow");
  endtask

  // ---------------- main ----------------
  initial begin
    drv_a = 1'b0; drv_b = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {2'b0, tx_line_a, tx_line_b, rpt_line_a, rpt_line_b, rx_valid, sys_tick}, 8'h00);
    rst_n = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      // R2 period of four fast cycles
      check("R2 tick", {7'b0, sys_tick}, {7'b0, (k % 4 == 3)});
    end

    run_tx(1'b0);
    run_tx(1'b1);

    lb = 1'b0;
    ml_d = 1'b0; ml_s = 1'b0; rd = 1'b0; rs = 1'b0;
    h1 = 2'b0; h2 = 2'b0;
    run_rx(1'b0);
    run_rx(1'b1);

    // R8 disable mid-group: partial group dropped, bits ignored, repeat idle
    wide_mode = 1'b0;
    wait_tick();
    idle_cycles(4);
    send_bit(1'b1, 3);
    set_en(1'b0);
    send_bit(1'b0, 2);
    send_bit(1'b1, 3);
    send_bit(1'b1, 2);
    idle_cycles(3);
    check("R8 repeat idle", {6'b0, rpt_line_b, rpt_line_a}, 8'h00);
    set_en(1'b1);
    idle_cycles(2);
    send_bit(1'b1, 2);
    send_bit(1'b0, 2);
    exp_q.push_back(4'h1);
    idle_cycles(16);
    cmp_words("R8 R7 discard");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule